// File: doc/BRIEF.md
# Dual-Mode Interval and PWM Timer

This block is an 8-bit timer whose one counter serves two uses. In interval mode the counter advances at a selected rate. When it reaches a compare value it returns to zero, raises a sticky match flag, and toggles the output pin, so the pin carries a square wave. In PWM mode the counter runs freely over 256 steps, and the pin is high while the count is below a duty value.

The counting rate comes from a shared prescaler. It can step on every instruction-cycle tick, on every 16th tick, on every 64th tick, or on each tick from a neighbouring capture timer. In PWM mode these four choices give periods of 256, 4096 or 16384 instruction cycles, or 256 external ticks. Software starts and stops the timer with a start bit, clears the flag with a clear strobe, and gates the interrupt request with an enable.

Top module: `ivpwm_timer`

## Requirements
- R1: After reset `pin_o`, `flag_o` and `irq_o` are 0.
- R2: `rate_sel` picks the counter step. 0 steps on every `tick_inst`, 1 on every 16th `tick_inst`, 2 on every 64th `tick_inst`, and 3 on every `tick_ext`. In modes 0 to 2, `tick_ext` is ignored.
- R3: In interval mode (`pwm_mode`=0), a step taken while the count equals `cmp_val` returns the count to 0 and sets the flag. The match therefore repeats every `cmp_val`+1 steps.
- R4: In interval mode the pin toggles on every match, starting from low after each start.
- R5: The flag stays set until a `flag_clr` pulse arrives. If a match and `flag_clr` fall in the same cycle, the flag ends up set.
- R6: `irq_o` is high exactly when the flag is set and `irq_en` is 1.
- R7: In PWM mode the counter wraps every 256 steps, and the pin is high while the count is below the latched duty. Duty 0 keeps the pin low, and duty 255 gives 255 high steps out of 256.
- R8: In PWM mode a new `cmp_val` is latched only when the counter wraps to 0. While stopped, `cmp_val` is latched directly.
- R9: While `start` is 0 the pin is low, and the counter and prescaler are held at 0. A new start therefore begins from count 0.
- R10: PWM mode never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_inst | input | 1 | Instruction-cycle tick |
| tick_ext | input | 1 | Tick from neighbouring capture timer |
| pwm_mode | input | 1 | 0 interval/square wave, 1 PWM |
| rate_sel | input | 2 | Step rate choice (see R2) |
| start | input | 1 | Run enable |
| cmp_val | input | 8 | Compare value (interval) or duty (PWM) |
| flag_clr | input | 1 | Pulse to clear the match flag |
| irq_en | input | 1 | Interrupt request enable |
| pin_o | output | 1 | Square-wave or PWM output |
| irq_o | output | 1 | Interrupt request |
| flag_o | output | 1 | Match flag |

## Verification
A compare match and a software clear of the flag can land in the same clock cycle. The bench first observes a pin toggle, which marks a match edge. It then counts to the following match edge of a short interval and holds `flag_clr` high for that single cycle. It checks that the flag stays set and that the pin toggled again, and it makes a separate clear on a non-match cycle to show that clearing does work on its own.

// File: rtl/ivpwm_timer.sv
module ivpwm_timer #(
  parameter int W       = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_inst,
  input  logic         tick_ext,
  input  logic         pwm_mode,
  input  logic [1:0]   rate_sel,
  input  logic         start,
  input  logic [W-1:0] cmp_val,
  input  logic         flag_clr,
  input  logic         irq_en,
  output logic         pin_o,
  output logic         irq_o,
  output logic         flag_o
);

  localparam int PW = $clog2(DIV_HI);
  localparam int MW = $clog2(DIV_MID);

  logic [PW-1:0] pre;
  logic [W-1:0]  cnt, duty_q;
  logic          sq, flag, step;

  always_comb begin
    case (rate_sel)
      2'd0:    step = tick_inst;
      2'd1:    step = tick_inst && (pre[MW-1:0] == '1);
      2'd2:    step = tick_inst && (pre == '1);
      default: step = tick_ext;
    endcase
  end

  wire hit   = (cnt == cmp_val);
  wire match = start && !pwm_mode && step && hit;
  wire wrap  = step && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      cnt    <= '0;
      sq     <= 1'b0;
      duty_q <= '0;
    end else if (!start) begin
      pre    <= '0;
      cnt    <= '0;
      sq     <= 1'b0;
      duty_q <= cmp_val;
    end else begin
      if (tick_inst) pre <= pre + 1'b1;
      if (step) begin
        if (pwm_mode) begin
          cnt <= cnt + 1'b1;
          if (wrap) duty_q <= cmp_val;
        end else if (hit) begin
          cnt <= '0;
          sq  <= ~sq;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (match)    flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  assign pin_o  = start && (pwm_mode ? (cnt < duty_q) : sq);
  assign flag_o = flag;
  assign irq_o  = flag && irq_en;

endmodule

// File: rtl/ivpwm_timer_chk.sv
module ivpwm_timer_chk #(
  parameter int W  = 8,
  parameter int PW = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         pwm_mode,
  input logic         step,
  input logic         flag_clr,
  input logic [W-1:0] cmp_val,
  input logic [W-1:0] cnt,
  input logic [W-1:0] duty_q,
  input logic [PW-1:0] pre,
  input logic         sq,
  input logic         flag,
  input logic         pin_o
);

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cnt == '0 && pre == '0)); // R9

  AST_STOP_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> !pin_o); // R9

  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pwm_mode && step && cnt == cmp_val) |=> (flag && cnt == '0)); // R3

  AST_MATCH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pwm_mode && step && cnt == cmp_val) |=> (sq != $past(sq))); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R5

  AST_PWM_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !flag) |=> !flag); // R10

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pwm_mode && !(step && cnt == '1)) |=> (duty_q == $past(duty_q))); // R8

endmodule

bind ivpwm_timer ivpwm_timer_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pwm_mode(pwm_mode),
  .step(step), .flag_clr(flag_clr), .cmp_val(cmp_val), .cnt(cnt),
  .duty_q(duty_q), .pre(pre), .sq(sq), .flag(flag), .pin_o(pin_o)
);

// File: tb/ivpwm_timer_tb_top.sv
`timescale 1ns/1ps
module ivpwm_timer_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_inst, tick_ext;
  logic pwm_mode = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic start = 1'b0;
  logic [7:0] cmp_val = 8'd0;
  logic flag_clr = 1'b0;
  logic irq_en = 1'b0;
  logic pin_o, irq_o, flag_o;

  int errors = 0;
  int checks = 0;
  int inst_div = 1;
  int ext_div = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ivpwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_inst(tick_inst), .tick_ext(tick_ext),
    .pwm_mode(pwm_mode), .rate_sel(rate_sel), .start(start), .cmp_val(cmp_val),
    .flag_clr(flag_clr), .irq_en(irq_en), .pin_o(pin_o), .irq_o(irq_o), .flag_o(flag_o)
  );

  initial begin
    int ip = 0;
    int ep = 0;
    tick_inst = 1'b1;
    tick_ext = 1'b0;
    forever begin
      @(negedge clk);
      ip = (ip + 1 >= inst_div) ? 0 : ip + 1;
      tick_inst = (ip == 0);
      if (ext_div == 0) tick_ext = 1'b0;
      else begin
        ep = (ep + 1 >= ext_div) ? 0 : ep + 1;
        tick_ext = (ep == 0);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input bit mode, input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    pwm_mode = mode;
    rate_sel = sel;
    cmp_val  = v;
    @(negedge clk);
    start = 1'b1;
  endtask

  task automatic wait_toggle(output int n);
    logic p0;
    p0 = pin_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pin_o == p0 && n < 30000);
  endtask

  task automatic period(output int p);
    int d;
    wait_toggle(d);
    wait_toggle(p);
  endtask

  task automatic count_high(input int len, output int h);
    h = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pin_o) h++;
    end
  endtask

  task automatic t_reset;
    chk(pin_o == 0 && flag_o == 0 && irq_o == 0, "R1 reset outputs", {pin_o, flag_o, irq_o}, 0);
  endtask

  task automatic t_rates;
    int p;
    inst_div = 1; ext_div = 0;
    cfg(0, 2'd0, 8'd4); period(p);
    chk(p == 5, "R3 interval period cmp=4 sel0", p, 5);
    cfg(0, 2'd1, 8'd2); period(p);
    chk(p == 48, "R2 sel1 divide by 16", p, 48);
    cfg(0, 2'd2, 8'd1); period(p);
    chk(p == 128, "R2 sel2 divide by 64", p, 128);
    inst_div = 2;
    cfg(0, 2'd0, 8'd4); period(p);
    chk(p == 10, "R2 sel0 follows tick_inst", p, 10);
    inst_div = 1; ext_div = 3;
    cfg(0, 2'd3, 8'd3); period(p);
    chk(p == 12, "R2 sel3 external tick", p, 12);
    cfg(0, 2'd0, 8'd3); period(p);
    chk(p == 4, "R2 tick_ext ignored in sel0", p, 4);
    ext_div = 0;
  endtask

  task automatic t_restart;
    cfg(0, 2'd0, 8'd5);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk(pin_o == 0, "R4 pin low before first match", pin_o, 0);
    @(negedge clk);
    chk(pin_o == 1, "R9 first toggle 6 cycles after start", pin_o, 1);
  endtask

  task automatic t_flag;
    int d;
    logic p0;
    cfg(0, 2'd0, 8'd3);
    irq_en = 1'b0;
    wait_toggle(d);
    chk(flag_o == 1, "R3 flag set on match", flag_o, 1);
    chk(irq_o == 0, "R6 irq masked", irq_o, 0);
    irq_en = 1'b1;
    #1;
    chk(irq_o == 1, "R6 irq follows flag", irq_o, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(flag_o == 0 && irq_o == 0, "R5 clear on non-match cycle", flag_o, 0);
    wait_toggle(d);
    @(negedge clk); @(negedge clk);
    chk(flag_o == 1, "R5 flag sticky", flag_o, 1);
    @(negedge clk);
    p0 = pin_o;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(pin_o != p0, "R4 toggle on collision cycle", pin_o, !p0);
    chk(flag_o == 1, "R5 set wins over clear", flag_o, 1);
    irq_en = 1'b0;
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_pwm;
    int h;
    cfg(1, 2'd0, 8'd128); count_high(256, h);
    chk(h == 128, "R7 duty 128", h, 128);
    cfg(1, 2'd0, 8'd0); count_high(256, h);
    chk(h == 0, "R7 duty 0 constant low", h, 0);
    cfg(1, 2'd0, 8'd255); count_high(256, h);
    chk(h == 255, "R7 duty 255", h, 255);
    cfg(1, 2'd1, 8'd64); count_high(4096, h);
    chk(h == 1024, "R7 sel1 period 4096", h, 1024);
    chk(flag_o == 0, "R10 no flag in PWM", flag_o, 0);
  endtask

  task automatic t_pwm_update;
    int h;
    cfg(1, 2'd0, 8'd200);
    for (int i = 0; i < 10; i++) @(negedge clk);
    cmp_val = 8'd50;
    count_high(100, h);
    chk(h == 100, "R8 old duty kept mid-period", h, 100);
    for (int i = 0; i < 300; i++) @(negedge clk);
    count_high(256, h);
    chk(h == 50, "R8 new duty after wrap", h, 50);
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(pin_o == 0, "R9 stop forces pin low", pin_o, 0);
    count_high(20, h);
    chk(h == 0, "R9 pin stays low while stopped", h, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rates();
    t_restart();
    t_flag();
    t_pwm();
    t_pwm_update();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule